// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block holds the eight-bit status byte of an I2C controller. It tracks whether this node currently owns the bus as master. It records a lost arbitration until software reads it. It flags the most recent bus condition seen on the wires, either a start or a stop, and it mirrors four live protocol indications into the byte. SCL and SDA arrive asynchronously. The block synchronizes them and finds start and stop conditions itself. All other event inputs are one-cycle strobes or levels, synchronous to the system clock, that come from the controller's bit engine.

Software reads the byte on `stat_byte`. A read strobe tells the block that the read happened, and that read clears the arbitration-loss flag. A single-bit write aimed at another register clears the whole byte. For this reason, software must sample the arbitration-loss bit before any other bit.

Two state machines shape the byte:

- **Master-status machine.** Its states are `MS_STANDBY`, `MS_MASTER` and `MS_LOST`.
  - `MS_STANDBY` goes to `MS_MASTER` when this node generates a start.
  - `MS_MASTER` goes to `MS_STANDBY` on a stop detect or on the release command.
  - `MS_LOST` goes to `MS_STANDBY` on a status read.
  - Any state goes to `MS_LOST` on arbitration loss.
  - Any state goes to `MS_STANDBY` when the enable is low or a foreign bit operation arrives.
- **View machine.** Its states are `VW_LIVE` and `VW_HELD`.
  - `VW_LIVE` goes to `VW_HELD` when the wakeup mode is switched off. On that transition it snapshots the byte.
  - `VW_HELD` goes back to `VW_LIVE` on the next detected start or stop.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset `stat_byte` is 0x00. The bit layout is: bit7 master, bit6 arbitration lost, bit5 extension code, bit4 address match, bit3 transmit direction, bit2 ACK detected, bit1 start seen, bit0 stop seen.
- R2: In standby with no arbitration loss, a `start_gen` strobe sets bit7 on the next clock edge.
- R3: An `arb_lost` strobe sets bit6 and clears bit7 on the same edge.
- R4: While master, a detected stop or a `rel_cmd` strobe clears bit7.
- R5: A `rd_stb` clears bit6 on the next edge. If `arb_lost` arrives in the same cycle as the read, bit6 stays set.
- R6: While `en` is low, every flag is 0 and all event strobes are ignored.
- R7: A `bitop_other` strobe clears the whole byte on the next edge. Only an `arb_lost` in the same cycle still sets bit6.
- R8: A start condition (SDA falls while SCL is high) sets bit1 and clears bit0. A stop condition (SDA rises while SCL is high) sets bit0 and clears bit1. Each shows SYNC_STAGES+1 edges after the SDA change. SDA changes while SCL is low have no effect.
- R9: Bits 5..2 follow `ext_code`, `addr_match`, `trc_in` and `ack_det` with one edge of latency.
- R10: After `wake_mode` falls from 1 to 0, `stat_byte` holds its value until the next detected start or stop. It then shows the live flags.
- R11: While bit6 is set, a `start_gen` strobe has no effect on bit7 until the byte has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| en | input | 1 | module enable |
| scl_in | input | 1 | raw SCL line |
| sda_in | input | 1 | raw SDA line |
| start_gen | input | 1 | strobe: this node issued a start |
| arb_lost | input | 1 | strobe: arbitration result is a loss |
| rel_cmd | input | 1 | strobe: leave communication |
| rd_stb | input | 1 | strobe: status byte read |
| bitop_other | input | 1 | strobe: single-bit write to another register |
| wake_mode | input | 1 | address-match wakeup mode enabled |
| trc_in | input | 1 | transmit direction level |
| ack_det | input | 1 | acknowledge detected level |
| addr_match | input | 1 | own address matched level |
| ext_code | input | 1 | extension code received level |
| stat_byte | output | 8 | status byte |

## Verification
The bench builds the block with SYNC_STAGES at its default of 2. This keeps the bus-condition latency at three edges, so the bench can check the cycle before a flag appears as well as the cycle it appears in. With that short latency, the bench can sweep all sixteen combinations of the mirrored bits. It also walks every transition of both state machines, including the colliding strobes where a set must win over a read or a foreign clear.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
    localparam int STAT_W = 8;
    localparam int B_MST  = 7;
    localparam int B_ALD  = 6;
    localparam int B_EXC  = 5;
    localparam int B_ADM  = 4;
    localparam int B_TRC  = 3;
    localparam int B_ACK  = 2;
    localparam int B_STD  = 1;
    localparam int B_SPD  = 0;

    typedef enum logic [1:0] {
        MS_STANDBY = 2'd0,
        MS_MASTER  = 2'd1,
        MS_LOST    = 2'd2
    } mst_st_e;

    typedef enum logic {
        VW_LIVE = 1'b0,
        VW_HELD = 1'b1
    } view_st_e;
endpackage

// File: rtl/i2c_bus_cond_det.sv
module i2c_bus_cond_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_p,
    output logic stop_p
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sh;
    logic [TOP:0] sda_sh;
    logic         sda_prev;
    logic         scl_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            sda_prev <= 1'b1;
            scl_prev <= 1'b1;
        end else begin
            scl_sh[0] <= scl_in;
            sda_sh[0] <= sda_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                scl_sh[i] <= scl_sh[i-1];
                sda_sh[i] <= sda_sh[i-1];
            end
            sda_prev <= sda_sh[TOP];
            scl_prev <= scl_sh[TOP];
        end
    end

    always_comb begin
        start_p = scl_sh[TOP] && scl_prev &&  sda_prev && !sda_sh[TOP];
        stop_p  = scl_sh[TOP] && scl_prev && !sda_prev &&  sda_sh[TOP];
    end
endmodule

// File: rtl/i2c_stat_mst_fsm.sv
module i2c_stat_mst_fsm
    import i2c_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start_gen,
    input  logic arb_lost,
    input  logic stop_p,
    input  logic rel_cmd,
    input  logic rd_stb,
    input  logic bitop_other,
    output logic msts,
    output logic ald
);
    mst_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MS_STANDBY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = MS_STANDBY;
        end else if (arb_lost) begin
            st_d = MS_LOST;
        end else if (bitop_other) begin
            st_d = MS_STANDBY;
        end else begin
            unique case (st_q)
                MS_STANDBY: if (start_gen)          st_d = MS_MASTER;
                MS_MASTER:  if (stop_p || rel_cmd)  st_d = MS_STANDBY;
                MS_LOST:    if (rd_stb)             st_d = MS_STANDBY;
                default:                            st_d = MS_STANDBY;
            endcase
        end
    end

    always_comb begin
        msts = (st_q == MS_MASTER);
        ald  = (st_q == MS_LOST);
    end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       bitop_other,
    input  logic       start_p,
    input  logic       stop_p,
    input  logic       ext_code,
    input  logic       addr_match,
    input  logic       trc_in,
    input  logic       ack_det,
    output logic [3:0] mirror,
    output logic       std,
    output logic       spd
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mirror <= '0;
            std    <= 1'b0;
            spd    <= 1'b0;
        end else if (!en || bitop_other) begin
            mirror <= '0;
            std    <= 1'b0;
            spd    <= 1'b0;
        end else begin
            mirror <= {ext_code, addr_match, trc_in, ack_det};
            if (start_p) begin
                std <= 1'b1;
                spd <= 1'b0;
            end else if (stop_p) begin
                std <= 1'b0;
                spd <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_stat_view.sv
module i2c_stat_view
    import i2c_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_mode,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic [STAT_W-1:0] live,
    output logic [STAT_W-1:0] shown,
    output logic              held
);
    view_st_e          vst_q, vst_d;
    logic              wake_q;
    logic [STAT_W-1:0] snap_q;
    logic              wake_fall;

    assign wake_fall = wake_q && !wake_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vst_q  <= VW_LIVE;
            wake_q <= 1'b0;
            snap_q <= '0;
        end else begin
            vst_q  <= vst_d;
            wake_q <= wake_mode;
            if (vst_q == VW_LIVE && wake_fall) snap_q <= live;
        end
    end

    always_comb begin
        vst_d = vst_q;
        unique case (vst_q)
            VW_LIVE: if (wake_fall)          vst_d = VW_HELD;
            VW_HELD: if (start_p || stop_p)  vst_d = VW_LIVE;
            default:                         vst_d = VW_LIVE;
        endcase
    end

    always_comb begin
        held  = (vst_q == VW_HELD);
        shown = held ? snap_q : live;
    end
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
    import i2c_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              start_gen,
    input  logic              arb_lost,
    input  logic              rel_cmd,
    input  logic              rd_stb,
    input  logic              bitop_other,
    input  logic              wake_mode,
    input  logic              trc_in,
    input  logic              ack_det,
    input  logic              addr_match,
    input  logic              ext_code,
    output logic [STAT_W-1:0] stat_byte
);
    logic              start_p, stop_p;
    logic              msts, ald, std, spd, held;
    logic [3:0]        mirror;
    logic [STAT_W-1:0] live;

    i2c_bus_cond_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .start_p(start_p), .stop_p(stop_p)
    );

    i2c_stat_mst_fsm u_mst (
        .clk(clk), .rst_n(rst_n), .en(en), .start_gen(start_gen),
        .arb_lost(arb_lost), .stop_p(stop_p), .rel_cmd(rel_cmd),
        .rd_stb(rd_stb), .bitop_other(bitop_other), .msts(msts), .ald(ald)
    );

    i2c_stat_flags u_flg (
        .clk(clk), .rst_n(rst_n), .en(en), .bitop_other(bitop_other),
        .start_p(start_p), .stop_p(stop_p), .ext_code(ext_code),
        .addr_match(addr_match), .trc_in(trc_in), .ack_det(ack_det),
        .mirror(mirror), .std(std), .spd(spd)
    );

    always_comb begin
        live = '0;
        live[B_MST] = msts;
        live[B_ALD] = ald;
        live[B_EXC] = mirror[3];
        live[B_ADM] = mirror[2];
        live[B_TRC] = mirror[1];
        live[B_ACK] = mirror[0];
        live[B_STD] = std;
        live[B_SPD] = spd;
    end

    i2c_stat_view u_view (
        .clk(clk), .rst_n(rst_n), .wake_mode(wake_mode), .start_p(start_p),
        .stop_p(stop_p), .live(live), .shown(stat_byte), .held(held)
    );
endmodule

// File: rtl/i2c_stat_reg_chk.sv
module i2c_stat_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       start_gen,
    input logic       arb_lost,
    input logic       rd_stb,
    input logic       bitop_other,
    input logic       start_p,
    input logic       stop_p,
    input logic       msts,
    input logic       ald,
    input logic       std,
    input logic       spd,
    input logic       held,
    input logic [7:0] live,
    input logic [7:0] stat_byte
);
    p_start_sets_mst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en && start_gen && !arb_lost && !bitop_other && !msts && !ald |=> msts);
    p_ald_forces_mst_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en && arb_lost |=> ald && !msts);
    p_stop_ends_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p && !start_gen |=> !msts);
    p_read_clears_ald_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !arb_lost |=> !ald);
    p_disabled_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> live == 8'h00);
    p_bitop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bitop_other && !arb_lost |=> live == 8'h00);
    p_std_spd_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(std && spd));
    p_held_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        held && !start_p && !stop_p |=> $stable(stat_byte));
endmodule

bind i2c_stat_reg i2c_stat_reg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .start_gen(start_gen),
    .arb_lost(arb_lost), .rd_stb(rd_stb), .bitop_other(bitop_other),
    .start_p(start_p), .stop_p(stop_p), .msts(msts), .ald(ald),
    .std(std), .spd(spd), .held(held), .live(live), .stat_byte(stat_byte)
);

// File: tb/i2c_stat_reg_tb.sv
module i2c_stat_reg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, scl_in = 1'b1, sda_in = 1'b1;
    logic start_gen = 0, arb_lost = 0, rel_cmd = 0, rd_stb = 0, bitop_other = 0;
    logic wake_mode = 0, trc_in = 0, ack_det = 0, addr_match = 0, ext_code = 0;
    logic [7:0] stat_byte;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_stat_reg #(.SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in), .sda_in(sda_in),
        .start_gen(start_gen), .arb_lost(arb_lost), .rel_cmd(rel_cmd),
        .rd_stb(rd_stb), .bitop_other(bitop_other), .wake_mode(wake_mode),
        .trc_in(trc_in), .ack_det(ack_det), .addr_match(addr_match),
        .ext_code(ext_code), .stat_byte(stat_byte)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mirror(input logic [3:0] v);
        {ext_code, addr_match, trc_in, ack_det} = v;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(3);
        chk("R1 reset", stat_byte, 8'h00);
        rst_n = 1'b1;
        en = 1'b1;
        cyc(2);
        chk("R1 after enable", stat_byte, 8'h00);

        // R9: sweep every mirror combination; bits 5..2
        for (int v = 0; v < 16; v++) begin
            set_mirror(v[3:0]);
            cyc(1);
            chk("R9 mirror", stat_byte, 8'(v << 2));
        end
        set_mirror(4'h0);
        cyc(1);

        // R2: start_gen from standby
        start_gen = 1; cyc(1); start_gen = 0;
        chk("R2 master set", stat_byte, 8'h80);

        // R8: bus start, check one edge early then on time
        sda_in = 0;
        cyc(SYNC);
        chk("R8 start not yet", stat_byte, 8'h80);
        cyc(1);
        chk("R8 start seen", stat_byte, 8'h82);

        // R4/R8: bus stop ends master, swaps flags
        sda_in = 1;
        cyc(LAT);
        chk("R4 R8 stop", stat_byte, 8'h01);

        // R8: SDA edges with SCL low ignored
        scl_in = 0; cyc(LAT);
        sda_in = 0; cyc(LAT);
        sda_in = 1; cyc(LAT);
        chk("R8 scl low ignored", stat_byte, 8'h01);
        scl_in = 1; cyc(LAT);
        chk("R8 scl rise ignored", stat_byte, 8'h01);

        // R4: release command
        start_gen = 1; cyc(1); start_gen = 0;
        chk("R2 master again", stat_byte, 8'h81);
        rel_cmd = 1; cyc(1); rel_cmd = 0;
        chk("R4 release", stat_byte, 8'h01);

        // R3: arbitration loss while master
        start_gen = 1; cyc(1); start_gen = 0;
        arb_lost = 1; cyc(1); arb_lost = 0;
        chk("R3 lost", stat_byte, 8'h41);

        // R11: start_gen ignored while lost
        start_gen = 1; cyc(1); start_gen = 0;
        chk("R11 start ignored", stat_byte, 8'h41);

        // R5: read clears; read with set keeps
        rd_stb = 1; cyc(1); rd_stb = 0;
        chk("R5 read clears", stat_byte, 8'h01);
        rd_stb = 1; arb_lost = 1; cyc(1); rd_stb = 0; arb_lost = 0;
        chk("R5 set wins", stat_byte, 8'h41);

        // R7: foreign bit op clears whole byte
        set_mirror(4'hF); cyc(1);
        chk("R7 pre", stat_byte, 8'h7D);
        bitop_other = 1; cyc(1); bitop_other = 0;
        chk("R7 cleared", stat_byte, 8'h00);
        set_mirror(4'h0);
        arb_lost = 1; bitop_other = 1; cyc(1); arb_lost = 0; bitop_other = 0;
        chk("R7 ald survives", stat_byte, 8'h40);
        rd_stb = 1; cyc(1); rd_stb = 0;

        // R6: enable low
        start_gen = 1; cyc(1); start_gen = 0;
        set_mirror(4'hA);
        en = 0; cyc(1);
        chk("R6 disabled clear", stat_byte, 8'h00);
        start_gen = 1; arb_lost = 1; cyc(1); start_gen = 0; arb_lost = 0;
        sda_in = 0; cyc(LAT);
        chk("R6 events ignored", stat_byte, 8'h00);
        sda_in = 1; cyc(LAT);
        set_mirror(4'h0);
        en = 1; cyc(1);
        chk("R6 re-enabled", stat_byte, 8'h00);

        // R10: freeze view after wakeup mode turns off
        wake_mode = 1; cyc(1);
        start_gen = 1; cyc(1); start_gen = 0;
        chk("R10 pre", stat_byte, 8'h80);
        wake_mode = 0; cyc(1);
        rel_cmd = 1; cyc(1); rel_cmd = 0;
        set_mirror(4'h5); cyc(2);
        chk("R10 held", stat_byte, 8'h80);
        sda_in = 0;
        cyc(SYNC);
        chk("R10 still held", stat_byte, 8'h80);
        cyc(1);
        chk("R10 released", stat_byte, 8'h16);
        set_mirror(4'h0);
        sda_in = 1; cyc(LAT);
        chk("R10 live after", stat_byte, 8'h01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule